// File: doc/BRIEF.md
# Hardware Cursor Pixel Compositor

This block lays a 4-bit-per-pixel cursor image over a stream of 24-bit RGB background pixels. Cursor data comes in as 64-bit words. Each word carries 16 pixel codes, and two words make up one 32-pixel cursor row. For every background pixel that is accepted, the block takes the next 4-bit code from the current word and uses it to build the output pixel. Depending on the code, the background is passed through, inverted, replaced with one of two programmed colours, or replaced with a grey level taken from the code itself.

All three streams use a valid/ready handshake. The block accepts at most one pixel per clock, and each result comes out of a single output register one cycle later. When the upstream side offers the next cursor word in time, it is loaded in the same cycle that the last code of the current word is used, so the stream does not stall at word boundaries. A row-end flag travels with the final pixel of each row. Deciding where the cursor sits on the screen and fetching its words from memory are done outside this block.

Top module: `hwcur_compose`

## Requirements
- R1: After reset, `out_valid` is 0, `cw_ready` is 1 and `bg_ready` is 0. The first pixel accepted after reset uses the most significant code of the first word loaded after reset, and any partly used word from before reset is thrown away.
- R2: The codes of a word are used from the most significant nibble down. Pixel k of a word uses bits [63-4k : 60-4k].
- R3: Code 0 outputs the background pixel unchanged.
- R4: Code 1 outputs the bitwise complement of all 24 background bits.
- R5: Code 8 outputs `color0` and code 9 outputs `color1`. Each colour is laid out as red in [23:16], green in [15:8] and blue in [7:0].
- R6: Every other code c (2 to 7 and 10 to 15) outputs a pixel whose red, green and blue bytes each equal c, zero-extended to 8 bits.
- R7: A pixel accepted on a clock edge (`bg_valid` and `bg_ready` both high) is presented on `out_pix` with `out_valid` high right after that same edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_pix` and `out_eol` hold their values and `bg_ready` is low.
- R9: A word is loaded when `cw_valid` and `cw_ready` are both high. `cw_ready` is also high in the cycle where the 16th code is being used. If the next word is waiting, `bg_ready` therefore stays high across the word boundary.
- R10: `out_eol` is 1 only with the 32nd pixel of a row, which is the last code of the second word in that row.
- R11: While no cursor word is held, `bg_ready` stays low and no output pixel is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| color0 | input | 24 | Colour used for code 8 (R[23:16], G[15:8], B[7:0]) |
| color1 | input | 24 | Colour used for code 9 (R[23:16], G[15:8], B[7:0]) |
| cw_valid | input | 1 | Cursor word offered |
| cw_data | input | 64 | Cursor word, 16 codes, first code in the top nibble |
| cw_ready | output | 1 | Cursor word can be taken |
| bg_valid | input | 1 | Background pixel offered |
| bg_pix | input | 24 | Background RGB pixel |
| bg_ready | output | 1 | Background pixel can be taken |
| out_valid | output | 1 | Composited pixel present |
| out_ready | input | 1 | Downstream takes the composited pixel |
| out_pix | output | 24 | Composited RGB pixel |
| out_eol | output | 1 | Marks the last pixel of a cursor row |

## Verification
The bench aims at the word boundary. A design that takes the last code twice, skips it, or adds a bubble before the next word would show a wrong pixel at position 16 or a low `bg_ready` there. It also checks that the code map is exact at codes 1, 8 and 9, where a design that gets these wrong would send grey in place of inversion or palette colours. Three further cases are covered:
- Backpressure while the output register is full: a design that fails here overwrites or drops a held pixel.
- The row-end flag: a design that gets it wrong raises the flag at the end of every word instead of every second word.
- Reset in the middle of a word: a design that fails here leaves a stale code count behind.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;

  typedef enum logic [1:0] {
    ACT_PASS,
    ACT_INV,
    ACT_PAL,
    ACT_GREY
  } hwcur_act_e;

  localparam int unsigned CODE_BITS = 4;
  localparam logic [CODE_BITS-1:0] CODE_CLEAR = 4'd0;
  localparam logic [CODE_BITS-1:0] CODE_INV   = 4'd1;
  localparam logic [CODE_BITS-1:0] CODE_PAL0  = 4'd8;
  localparam logic [CODE_BITS-1:0] CODE_PAL1  = 4'd9;

  function automatic hwcur_act_e classify(input logic [CODE_BITS-1:0] c);
    hwcur_act_e a;
    if (c == CODE_CLEAR)                    a = ACT_PASS;
    else if (c == CODE_INV)                 a = ACT_INV;
    else if (c == CODE_PAL0 || c == CODE_PAL1) a = ACT_PAL;
    else                                    a = ACT_GREY;
    return a;
  endfunction

endpackage

// File: rtl/hwcur_word_buf.sv
module hwcur_word_buf #(
  parameter int unsigned WORD_W        = 64,
  parameter int unsigned CODE_W        = 4,
  parameter int unsigned WORDS_PER_ROW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_valid,
  input  logic [WORD_W-1:0] cw_data,
  output logic              cw_ready,
  input  logic              adv,
  output logic              have_word,
  output logic [CODE_W-1:0] code,
  output logic              row_end
);
  localparam int unsigned NIBS   = WORD_W / CODE_W;
  localparam int unsigned CNT_W  = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam int unsigned HALF_W = (WORDS_PER_ROW > 1) ? $clog2(WORDS_PER_ROW) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(NIBS - 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(WORDS_PER_ROW - 1);

  logic [WORD_W-1:0] word_q, word_n;
  logic              full_q, full_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [HALF_W-1:0] half_q, half_n;
  logic [CODE_W-1:0] nibs [NIBS];
  logic              last_nib, last_word, word_done, cw_fire;

  // Code slices, first code in the top nibble
  for (genvar i = 0; i < NIBS; i++) begin : g_nib
    assign nibs[i] = word_q[WORD_W-1-i*CODE_W -: CODE_W];
  end

  assign last_nib  = (cnt_q == CNT_LAST);
  assign last_word = (half_q == HALF_LAST);
  assign word_done = adv && last_nib;
  assign cw_ready  = !full_q || word_done;
  assign cw_fire   = cw_valid && cw_ready;
  assign have_word = full_q;
  assign code      = nibs[cnt_q];
  assign row_end   = last_nib && last_word;

  always_comb begin
    word_n = word_q;
    full_n = full_q;
    cnt_n  = cnt_q;
    half_n = half_q;
    if (adv) begin
      cnt_n = last_nib ? '0 : cnt_q + 1'b1;
    end
    if (word_done) begin
      full_n = 1'b0;
      half_n = last_word ? '0 : half_q + 1'b1;
    end
    if (cw_fire) begin
      word_n = cw_data;
      full_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
    end else begin
      full_q <= full_n;
      cnt_q  <= cnt_n;
      half_q <= half_n;
    end
  end

  always_ff @(posedge clk) begin
    if (cw_fire) word_q <= word_n;
  end

  // R9
  refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_fire |=> (have_word && cnt_q == '0));

endmodule

// File: rtl/hwcur_pix_map.sv
module hwcur_pix_map
  import hwcur_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CH_W   = 8,
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic [PIX_W-1:0]  bg,
  input  logic [PIX_W-1:0]  col0,
  input  logic [PIX_W-1:0]  col1,
  output logic [PIX_W-1:0]  pix
);
  logic [PIX_W-1:0] grey;
  hwcur_act_e       act;

  for (genvar ch = 0; ch < 3; ch++) begin : g_grey
    assign grey[ch*CH_W +: CH_W] = CH_W'(code);
  end

  assign act = classify(CODE_BITS'(code));

  always_comb begin
    unique case (act)
      ACT_PASS: pix = bg;
      ACT_INV:  pix = ~bg;
      ACT_PAL:  pix = code[0] ? col1 : col0;
      default:  pix = grey;
    endcase
  end

endmodule

// File: rtl/hwcur_out_stage.sv
module hwcur_out_stage #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_fire,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_eol,
  output logic             can_take,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_eol
);
  logic             vld_q, vld_n;
  logic [PIX_W-1:0] pix_q;
  logic             eol_q;

  assign can_take  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_pix   = pix_q;
  assign out_eol   = eol_q;

  always_comb begin
    vld_n = vld_q;
    if (in_fire)        vld_n = 1'b1;
    else if (out_ready) vld_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      pix_q <= in_pix;
      eol_q <= in_eol;
    end
  end

  // R7
  one_cycle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_eol)));

endmodule

// File: rtl/hwcur_compose.sv
module hwcur_compose #(
  parameter int unsigned WORD_W        = 64,
  parameter int unsigned CODE_W        = 4,
  parameter int unsigned CH_W          = 8,
  parameter int unsigned WORDS_PER_ROW = 2,
  localparam int unsigned PIX_W        = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  color0,
  input  logic [PIX_W-1:0]  color1,
  input  logic              cw_valid,
  input  logic [WORD_W-1:0] cw_data,
  output logic              cw_ready,
  input  logic              bg_valid,
  input  logic [PIX_W-1:0]  bg_pix,
  output logic              bg_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_eol
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              have_word, row_end, can_take, fire;
  logic [CODE_W-1:0] code;
  logic [PIX_W-1:0]  mapped;

  // Reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign bg_ready = have_word && can_take;
  assign fire     = bg_valid && bg_ready;

  hwcur_word_buf #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .WORDS_PER_ROW(WORDS_PER_ROW)
  ) u_wbuf (
    .clk(clk), .rst_n(rst_int_n),
    .cw_valid(cw_valid), .cw_data(cw_data), .cw_ready(cw_ready),
    .adv(fire), .have_word(have_word), .code(code), .row_end(row_end)
  );

  hwcur_pix_map #(.CODE_W(CODE_W), .CH_W(CH_W)) u_map (
    .code(code), .bg(bg_pix), .col0(color0), .col1(color1), .pix(mapped)
  );

  hwcur_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_int_n),
    .in_fire(fire), .in_pix(mapped), .in_eol(row_end),
    .can_take(can_take),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_eol(out_eol)
  );

  // R3
  clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire && code == CODE_W'(0)) |=> (out_pix == $past(bg_pix)));

  // R4
  invert_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire && code == CODE_W'(1)) |=> (out_pix == ~$past(bg_pix)));

  // R5
  pal0_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire && code == CODE_W'(8)) |=> (out_pix == $past(color0)));

  // R11
  no_word_no_out_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!have_word && !out_valid) |=> !out_valid);

endmodule

// File: tb/hwcur_compose_test.sv
`timescale 1ns/1ps
module hwcur_compose_test;
  localparam logic [23:0] C0 = 24'hA1B2C3;
  localparam logic [23:0] C1 = 24'h0D0E0F;
  localparam logic [63:0] TBL_WORD = 64'h0123_4567_89AB_CDEF;
  // {background, expected} for codes 0..15 in order
  localparam logic [47:0] TBL [16] = '{
    {24'h123456, 24'h123456}, {24'h0F0F0F, 24'hF0F0F0},
    {24'hFFFFFF, 24'h020202}, {24'h000000, 24'h030303},
    {24'h55AA55, 24'h040404}, {24'h123456, 24'h050505},
    {24'h654321, 24'h060606}, {24'h777777, 24'h070707},
    {24'h000000, 24'hA1B2C3}, {24'hFFFFFF, 24'h0D0E0F},
    {24'h123456, 24'h0A0A0A}, {24'h000000, 24'h0B0B0B},
    {24'h000000, 24'h0C0C0C}, {24'h000000, 24'h0D0D0D},
    {24'h000000, 24'h0E0E0E}, {24'h000000, 24'h0F0F0F}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cw_valid, cw_ready, bg_valid, bg_ready, out_valid, out_ready, out_eol;
  logic [63:0] cw_data;
  logic [23:0] bg_pix, out_pix;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  hwcur_compose uut (
    .clk(clk), .rst_n(rst_n), .color0(C0), .color1(C1),
    .cw_valid(cw_valid), .cw_data(cw_data), .cw_ready(cw_ready),
    .bg_valid(bg_valid), .bg_pix(bg_pix), .bg_ready(bg_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_eol(out_eol)
  );

  function automatic logic [23:0] ref_pix(input logic [3:0] c, input logic [23:0] bg);
    case (c)
      4'd0:    return bg;
      4'd1:    return ~bg;
      4'd8:    return C0;
      4'd9:    return C1;
      default: return {4'h0, c, 4'h0, c, 4'h0, c};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [63:0] w);
    @(negedge clk);
    cw_valid = 1'b1;
    cw_data  = w;
    forever begin
      #1;
      if (cw_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 cw_valid = 1'b0;
  endtask

  // Starts and ends on a falling edge; one pixel per cycle when called back to back
  task automatic do_pix(input string req, input logic [23:0] bg,
                        input logic [23:0] exp, input logic exp_eol);
    bg_valid = 1'b1;
    bg_pix   = bg;
    chk({req, " bg_ready"}, 32'(bg_ready), 32'd1);
    @(negedge clk);
    bg_valid = 1'b0;
    chk({req, " out_valid"}, 32'(out_valid), 32'd1);
    chk({req, " out_pix"}, 32'(out_pix), 32'(exp));
    chk({req, " out_eol"}, 32'(out_eol), 32'(exp_eol));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] wa, wb, w;
    logic [23:0] bg;
    cw_valid = 0; cw_data = '0; bg_valid = 0; bg_pix = '0; out_ready = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 cw_ready", 32'(cw_ready), 1);
    chk("R1 bg_ready", 32'(bg_ready), 0);

    // R11 no word: pixels are refused
    bg_valid = 1; bg_pix = 24'h111111;
    repeat (3) begin
      @(negedge clk);
      chk("R11 bg_ready", 32'(bg_ready), 0);
      chk("R11 out_valid", 32'(out_valid), 0);
    end
    bg_valid = 0;

    // R2..R7 table walk: codes 0..15 in order, first word of a row
    send_word(TBL_WORD);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      do_pix($sformatf("R2/R3-R6 code %0d", i), TBL[i][47:24], TBL[i][23:0], 1'b0);
    end

    // R8 backpressure, second word of the row (all transparent), R10 at its end
    send_word(64'h0);
    @(negedge clk);
    out_ready = 0;
    bg_valid = 1; bg_pix = 24'h000001;
    @(negedge clk);
    chk("R7 out_valid", 32'(out_valid), 1);
    chk("R7 out_pix", 32'(out_pix), 32'h000001);
    bg_pix = 24'h000002;
    repeat (2) begin
      chk("R8 bg_ready", 32'(bg_ready), 0);
      @(negedge clk);
      chk("R8 held pix", 32'(out_pix), 32'h000001);
      chk("R8 held valid", 32'(out_valid), 1);
    end
    out_ready = 1;
    @(negedge clk);
    chk("R8 drained next pix", 32'(out_pix), 32'h000002);
    for (int i = 3; i <= 16; i++) begin
      do_pix("R8/R10 stream", 24'(i), 24'(i), (i == 16));
    end

    // R9 R10 full row with the second word arriving while the first is in use
    wa = 64'h0198_A5F0_1234_9876;
    wb = 64'hFEDC_BA98_7654_3210;
    send_word(wa);
    fork
      send_word(wb);
      begin
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
          w  = (i < 16) ? wa : wb;
          bg = {8'(i), 8'hC3, 8'(i * 7)};
          do_pix($sformatf("R9/R10 row px %0d", i), bg,
                 ref_pix(w[63-4*(i%16) -: 4], bg), (i == 31));
        end
      end
    join

    // R1 reset in the middle of a word
    send_word(64'h9999_9999_9999_9999);
    @(negedge clk);
    for (int i = 0; i < 3; i++) do_pix("R1 pre-reset", 24'h0, C1, 1'b0);
    rst_n = 0;
    #1;
    chk("R1 mid reset out_valid", 32'(out_valid), 0);
    chk("R1 mid reset cw_ready", 32'(cw_ready), 1);
    chk("R1 mid reset bg_ready", 32'(bg_ready), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after reset bg_ready", 32'(bg_ready), 0);
    send_word(64'h8100_0000_0000_0000);
    @(negedge clk);
    do_pix("R1 restart first code", 24'h123456, C0, 1'b0);
    do_pix("R1 restart second code", 24'h123456, 24'hEDCBA9, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule